// File: doc/BRIEF.md
# Pixel Event Packet Formatter

The formatter wraps one readout of a pixel chip into a framed packet for a 32-bit serialiser. A readout is a fixed run of 32 words of 32 bits that together form the hit map of one event. The formatter puts two header words in front of the hit map and one trailer word after it. The headers carry the event number, the detector number, the bunch number and status bits. The trailer holds the column parity of the hit map, so a receiver can check that the link delivered the map intact.

The source marks the first word of each readout with a first flag. It presents the identifiers for that readout on side ports, and they stay valid while the first word waits. Hit words pass through to the output unchanged in the same cycle, so the source is stalled exactly when the serialiser stalls. No packet-sized buffer is needed. The first word of a readout is held off while its two header words go out.

Sometimes a new first word arrives before 32 hit words have been seen. The open packet is then closed at once with a trailer over the words received, and the next packet reports the cut in its status field.

Top module: `pef_packet_fmt`

## Requirements
- R1: Header word 0 is {8'hA5, event number[23:0]}, with the marker in bits 31:24.
- R2: Header word 1 is {detector number[7:0], bunch number[11:0], cut flag, status[10:0]}, with the cut flag in bit 11. The identifiers are those presented with the readout's first word.
- R3: A packet goes out as header 0, header 1, the 32 hit words in arrival order with their values unchanged, and then the trailer.
- R4: Bit k of the trailer is the XOR of bit k over the hit words of the packet (even parity). The header words are not included.
- R5: While out_valid is high and out_ready is low, no word is lost or repeated, and a header or trailer word keeps its value.
- R6: Out of reset, and whenever no packet is open, out_valid is low and out_data is the idle word 32'h0000_0000.
- R7: A first-flagged word arriving after 1 to 31 hit words of a packet ends that packet with a trailer over the words received. It then opens a new packet whose header 1 has the cut flag set. The following packet has the flag clear again.
- R8: A word presented while no packet is open, with the first flag low, is consumed (in_ready high) and produces no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Source word valid |
| in_first | input | 1 | Marks the first hit word of a readout |
| in_data | input | 32 | Hit word |
| in_ready | output | 1 | Formatter accepts the source word this cycle |
| evt_id | input | 24 | Event number, held with the first word |
| det_id | input | 8 | Detector number, held with the first word |
| bx_id | input | 12 | Bunch number, held with the first word |
| stat_in | input | 11 | Status bits, held with the first word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Serialiser accepts the output word |
| out_data | output | 32 | Output word |

## Verification
On every cycle the assertions check these behaviours. Headers advance only on a transfer, and a stalled header or trailer holds. Every accepted hit word leaves in the same cycle. The parity register is clean when a packet opens. The cut flag rises only while hit words are flowing. Nothing becomes valid while stray words are drained. Only the bench's scenarios can show that the packet contents are right: the exact header fields, the trailer parity, the cut flag on the packet after a truncation, and the full word sequence under a pseudo-random stall pattern.

// File: rtl/pef_pkg.sv
package pef_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR0  = 3'd1,
    ST_HDR1  = 3'd2,
    ST_DATA  = 3'd3,
    ST_TRAIL = 3'd4
  } pef_state_e;

endpackage

// File: rtl/pef_seq.sv
module pef_seq
  import pef_pkg::*;
#(
  parameter int N_WORDS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic       out_ready,
  output pef_state_e state,
  output logic       in_ready,
  output logic       out_valid,
  output logic       cap,
  output logic       beat,
  output logic       cut,
  output logic       hdr1_done,
  output logic       trail_done
);

  localparam int CNT_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_WORDS - 1);

  pef_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cap        = (state_q == ST_IDLE) && in_valid && in_first;
    cut        = (state_q == ST_DATA) && in_valid && in_first && (cnt_q != '0);
    beat       = (state_q == ST_DATA) && in_valid && out_ready && !cut;
    hdr1_done  = (state_q == ST_HDR1) && out_ready;
    trail_done = (state_q == ST_TRAIL) && out_ready;

    in_ready  = 1'b0;
    out_valid = 1'b0;
    unique case (state_q)
      ST_IDLE:  in_ready = !in_first;
      ST_HDR0,
      ST_HDR1,
      ST_TRAIL: out_valid = 1'b1;
      ST_DATA: begin
        in_ready  = out_ready && !cut;
        out_valid = in_valid && !cut;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cap) state_d = ST_HDR0;
      ST_HDR0:  if (out_ready) state_d = ST_HDR1;
      ST_HDR1:  if (out_ready) state_d = ST_DATA;
      ST_DATA: begin
        if (cut) state_d = ST_TRAIL;
        else if (beat && (cnt_q == LAST)) state_d = ST_TRAIL;
      end
      ST_TRAIL: if (out_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = beat || cut;
    if (cut || (cnt_q == LAST)) cnt_d = '0;
    else cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state = state_q;

  // R3: header 0 is always followed by header 1 once transferred
  a_r3_hdr_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR0 && out_ready) |=> (state_q == ST_HDR1));

  // R3: the last hit word leads straight to the trailer
  a_r3_full_to_trailer: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cnt_q == LAST) |=> (state_q == ST_TRAIL));

  // R5: a stalled header or trailer stays put
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HDR0 || state_q == ST_HDR1 || state_q == ST_TRAIL) && !out_ready)
      |=> $stable(state_q));

  // R8: stray words in idle are drained without output
  a_r8_idle_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && in_valid && !in_first) |-> (in_ready && !out_valid));

endmodule

// File: rtl/pef_col_parity.sv
module pef_col_parity #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add,
  input  logic              clr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] par
);

  logic [WORD_W-1:0] acc_q, acc_d;
  logic              acc_en;

  always_comb begin
    acc_en = add || clr;
    acc_d  = clr ? '0 : (acc_q ^ din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign par = acc_q;

  // R4: a hit word is never folded in during the clearing cycle
  a_r4_add_clr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(add && clr));

endmodule

// File: rtl/pef_hdr_build.sv
module pef_hdr_build #(
  parameter int          WORD_W = 32,
  parameter int          EVT_W  = 24,
  parameter int          DET_W  = 8,
  parameter int          BX_W   = 12,
  parameter int          STAT_W = 12,
  parameter logic [7:0]  MARKER = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              cut,
  input  logic              hdr1_done,
  input  logic [EVT_W-1:0]  evt_id,
  input  logic [DET_W-1:0]  det_id,
  input  logic [BX_W-1:0]   bx_id,
  input  logic [STAT_W-2:0] stat_in,
  output logic [WORD_W-1:0] hdr0,
  output logic [WORD_W-1:0] hdr1
);

  localparam int MARK_W = WORD_W - EVT_W;

  logic [EVT_W-1:0]  evt_q;
  logic [DET_W-1:0]  det_q;
  logic [BX_W-1:0]   bx_q;
  logic [STAT_W-2:0] st_q;
  logic              cut_q, cut_d, cut_en;

  always_comb begin
    cut_en = cut || hdr1_done;
    cut_d  = cut;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      det_q <= '0;
      bx_q  <= '0;
      st_q  <= '0;
    end else if (cap) begin
      evt_q <= evt_id;
      det_q <= det_id;
      bx_q  <= bx_id;
      st_q  <= stat_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cut_q <= 1'b0;
    else if (cut_en) cut_q <= cut_d;
  end

  assign hdr0 = {MARKER[MARK_W-1:0], evt_q};
  assign hdr1 = {det_q, bx_q, cut_q, st_q};

  // R7: a cut and a header-1 transfer never coincide
  a_r7_cut_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cut && hdr1_done));

endmodule

// File: rtl/pef_packet_fmt.sv
module pef_packet_fmt
  import pef_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          N_WORDS   = 32,
  parameter int          EVT_W     = 24,
  parameter int          DET_W     = 8,
  parameter int          BX_W      = 12,
  parameter int          STAT_W    = 12,
  parameter logic [7:0]  MARKER    = 8'hA5,
  parameter logic [31:0] IDLE_WORD = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic [EVT_W-1:0]  evt_id,
  input  logic [DET_W-1:0]  det_id,
  input  logic [BX_W-1:0]   bx_id,
  input  logic [STAT_W-2:0] stat_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  pef_state_e        state;
  logic              cap, beat, cut, hdr1_done, trail_done;
  logic [WORD_W-1:0] hdr0, hdr1, par;

  pef_seq #(.N_WORDS(N_WORDS)) seq_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .out_ready  (out_ready),
    .state      (state),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .cap        (cap),
    .beat       (beat),
    .cut        (cut),
    .hdr1_done  (hdr1_done),
    .trail_done (trail_done)
  );

  pef_hdr_build #(
    .WORD_W (WORD_W),
    .EVT_W  (EVT_W),
    .DET_W  (DET_W),
    .BX_W   (BX_W),
    .STAT_W (STAT_W),
    .MARKER (MARKER)
  ) hdr_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cap       (cap),
    .cut       (cut),
    .hdr1_done (hdr1_done),
    .evt_id    (evt_id),
    .det_id    (det_id),
    .bx_id     (bx_id),
    .stat_in   (stat_in),
    .hdr0      (hdr0),
    .hdr1      (hdr1)
  );

  pef_col_parity #(.WORD_W(WORD_W)) par_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .add   (beat),
    .clr   (trail_done),
    .din   (in_data),
    .par   (par)
  );

  always_comb begin
    unique case (state)
      ST_HDR0:  out_data = hdr0;
      ST_HDR1:  out_data = hdr1;
      ST_DATA:  out_data = in_data;
      ST_TRAIL: out_data = par;
      default:  out_data = IDLE_WORD[WORD_W-1:0];
    endcase
  end

  // R4: parity register is clean whenever a packet opens
  a_r4_par_clean: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_HDR0) |-> (par == '0));

  // R5: every accepted hit word leaves in the same cycle
  a_r5_no_loss: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_DATA && in_valid && in_ready) |-> (out_valid && out_ready));

  // R6: idle presents the idle word with valid low
  a_r6_idle_word: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_IDLE) |-> (!out_valid && out_data == IDLE_WORD[WORD_W-1:0]));

  // R7: the cut flag only rises while hit words are flowing
  a_r7_flag_rise: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(hdr1[STAT_W-1]) |-> ($past(state) == ST_DATA));

endmodule

// File: tb/pef_packet_fmt_tb.sv
`timescale 1ns/1ps
module pef_packet_fmt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_first, in_ready;
  logic [31:0] in_data;
  logic [23:0] evt_id;
  logic [7:0]  det_id;
  logic [11:0] bx_id;
  logic [10:0] stat_in;
  logic        out_valid, out_ready;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  pef_packet_fmt dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_first(in_first), .in_data(in_data), .in_ready(in_ready),
    .evt_id(evt_id), .det_id(det_id), .bx_id(bx_id), .stat_in(stat_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_w [0:1023];
  int          exp_r [0:1023];
  int          wr = 0;
  int          rd = 0;
  bit          exp_cut = 0;

  int          rmode = 0;   // 0 always ready, 1 pseudo-random, 2 held low
  logic [15:0] lfsr  = 16'hACE1;

  task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] dword(input int pid, input int i);
    if (pid == 100) return 32'h0000_0000;
    if (pid == 101) return 32'hFFFF_FFFF;
    return (32'(pid) * 32'h9E37_79B9) ^ (32'(i) * 32'h0001_0001) ^ (32'h1 << i);
  endfunction

  function automatic logic [23:0] f_evt(input int pid); return 24'(pid * 4951 + 5); endfunction
  function automatic logic [7:0]  f_det(input int pid); return 8'(pid) ^ 8'h3C; endfunction
  function automatic logic [11:0] f_bx (input int pid); return 12'(pid * 257); endfunction
  function automatic logic [10:0] f_st (input int pid); return 11'(pid * 677); endfunction

  task automatic push(input logic [31:0] w, input int req);
    exp_w[wr] = w;
    exp_r[wr] = req;
    wr++;
  endtask

  // present one source word and wait until it is accepted
  task automatic send_word(input logic [31:0] d, input bit first, input int pid);
    in_valid = 1'b1;
    in_first = first;
    in_data  = d;
    evt_id   = f_evt(pid);
    det_id   = f_det(pid);
    bx_id    = f_bx(pid);
    stat_in  = f_st(pid);
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  // a packet of n hit words; n < 32 leaves it to be cut by the next one (R7)
  task automatic send_pkt(input int pid, input int n);
    logic [31:0] p = 32'h0;
    push({8'hA5, f_evt(pid)}, 1);                        // R1
    push({f_det(pid), f_bx(pid), exp_cut, f_st(pid)}, 2); // R2
    exp_cut = (n < 32);
    for (int i = 0; i < n; i++) begin
      push(dword(pid, i), 3);                             // R3
      p ^= dword(pid, i);
    end
    push(p, 4);                                           // R4
    for (int i = 0; i < n; i++) send_word(dword(pid, i), (i == 0), pid);
  endtask

  task automatic drain();
    while (rd != wr) @(negedge clk);
    repeat (3) @(negedge clk);
    // R6: idle word with valid low once the packet is closed
    chk(!out_valid && out_data == 32'h0, 6, out_data, 32'h0);
  endtask

  // output driver for the serialiser side
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0] | lfsr[5];
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor: every transfer must match the next expected word (R1..R5)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (rd < wr) begin
        chk(out_data == exp_w[rd], exp_r[rd], out_data, exp_w[rd]);
        rd++;
      end else begin
        chk(1'b0, 8, out_data, 32'h0);                   // R8/R5: unexpected extra word
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_first = 1'b0;
    in_data  = '0;
    evt_id   = '0;
    det_id   = '0;
    bx_id    = '0;
    stat_in  = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6: reset state
    chk(!out_valid, 6, 32'(out_valid), 32'h0);
    chk(out_data == 32'h0, 6, out_data, 32'h0);

    // R1 R2 R3 R4 always ready, several patterns including all-zero and all-one maps
    send_pkt(1, 32);   drain();
    send_pkt(100, 32); drain();
    send_pkt(101, 32); drain();

    // R5: stall on header 0 holds valid and value
    rmode = 2;
    fork send_pkt(7, 32); join_none
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == {8'hA5, f_evt(7)}, 5, out_data, {8'hA5, f_evt(7)});
    end
    rmode = 1;
    wait fork;
    drain();

    // R5: pseudo-random stalls over many packets, R3/R4 sequence compared by monitor
    for (int p = 10; p < 22; p++) send_pkt(p, 32);
    drain();

    // R7: cut after 5 words; next packet carries the flag, the one after is clear
    send_pkt(30, 5);
    send_pkt(31, 32);
    send_pkt(32, 32);
    drain();
    // R7: cut after 31 words (upper boundary) and after 1 word (lower boundary)
    send_pkt(33, 31);
    send_pkt(34, 1);
    send_pkt(35, 32);
    drain();

    // R8: stray words in idle are consumed with no output
    rmode = 0;
    for (int k = 0; k < 3; k++) begin
      send_word(32'hDEAD_0000 + 32'(k), 1'b0, 0);
      @(negedge clk);
      chk(!out_valid, 8, 32'(out_valid), 32'h0);
    end
    send_pkt(40, 32);
    drain();
    chk(rd == wr, 3, 32'(rd), 32'(wr));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule